// File: doc/BRIEF.md
# Interleaved MSI Interrupt Aggregator

This block collects message-signalled interrupts and folds them onto a small set of level interrupt lines. Every inbound interrupt message delivers a vector number on the capture port. The vectors are interleaved across the lines: vector `v` belongs to line `v mod 8` and occupies bit `v >> 3` of that line's pending register. With 32 vectors and eight lines, each line therefore carries four pending bits.

Software works through a narrow register bus. Each line has three registers:

- a pending register, where a write of 1 clears a bit;
- an enable-set register, where a write of 1 turns a bit on;
- an enable-clear register, where a write of 1 turns a bit off.

A line's output is high while any of its pending bits is also enabled. After servicing, software writes `4 + r` to the acknowledge register. Line `r` then drops for exactly one cycle and is re-evaluated, so a vector that is still pending raises a fresh edge for an edge-sensitive interrupt controller.

Reset is asserted asynchronously and released through a two-stage synchronizer. Register state therefore leaves reset two clocks after `rst_n` rises.

Top module: `msi_agg`

## Requirements
- R1: After reset, every pending and enable register reads zero and all eight interrupt outputs are low.
- R2: A capture with `msi_valid` high and vector v in 0..31 sets bit (v >> 3) of line (v mod 8). That line's pending register is read at byte offset 0x104 + 16*(v mod 8), and the bit is visible on the next clock.
- R3: A capture whose vector is 32 or above changes no pending bit and no output.
- R4: Writing to a pending register clears exactly the bits written as 1 (bits 3:0). Bits written as 0 are kept.
- R5: Offset 0x108 + 16*r sets enable bits of line r, and 0x10C + 16*r clears them, in each case for bits written as 1. A read at either offset returns the line's current enable mask in bits 3:0.
- R6: `irq_o[r]` is high in the cycle after line r holds a bit that is both pending and enabled, and low when no such bit exists.
- R7: Writing 4 + r to offset 0x050 forces `irq_o[r]` low for exactly one cycle. The line then reasserts if a pending, enabled bit remains. Other lines are unaffected, and values outside 4..11 acknowledge nothing.
- R8: When a capture and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R9: A vector captured while disabled stays pending with its output low. Enabling it later raises the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| msi_valid | input | 1 | Capture strobe for one interrupt message |
| msi_vector | input | 8 | Vector number carried by the message |
| irq_o | output | 8 | Level interrupt line per group |

## Verification
The bench builds the block with its default parameters: eight lines of four bits each and an 8-bit vector input. This gives the full vector space 0..31 and also lets the bench drive out-of-range vector values such as 32, 40 and 255. The interleaved mapping is checked at both ends of the bit range, using vectors 0, 8, 17, 25 and 31. With eight lines, the bench can acknowledge one line while a neighbouring line stays pending, and confirm that only the addressed line blinks.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

  // Register kind selected by the low address nibble inside a line's bank
  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_STATUS = 2'd1,
    KIND_EN_SET = 2'd2,
    KIND_EN_CLR = 2'd3
  } reg_kind_e;

  localparam logic [3:0]  NIB_STATUS = 4'h4;
  localparam logic [3:0]  NIB_EN_SET = 4'h8;
  localparam logic [3:0]  NIB_EN_CLR = 4'hC;
  localparam int unsigned BANK_BASE  = 32'h100;
  localparam int unsigned LINE_STEP_LOG2 = 4;  // 16-byte spacing per line
  localparam int unsigned ACK_ADDR   = 32'h050;
  localparam int unsigned ACK_BIAS   = 4;      // acknowledge value = bias + line

endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/msi_capture_decode.sv
module msi_capture_decode #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned VEC_BITS  = 4,
  parameter int unsigned VEC_IN_W  = 8,
  localparam int unsigned TOTAL    = NUM_LINES * VEC_BITS
) (
  input  logic                msi_valid,
  input  logic [VEC_IN_W-1:0] msi_vector,
  output logic [TOTAL-1:0]    set_flat
);
  // Line-major flat layout: set_flat[line*VEC_BITS + bit]
  always_comb begin
    set_flat = '0;
    for (int ln = 0; ln < int'(NUM_LINES); ln++) begin
      for (int b = 0; b < int'(VEC_BITS); b++) begin
        if (msi_valid && (msi_vector == VEC_IN_W'(ln + b * int'(NUM_LINES))))
          set_flat[ln*VEC_BITS + b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/msi_regif.sv
module msi_regif
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned VEC_BITS  = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned TOTAL    = NUM_LINES * VEC_BITS,
  localparam int unsigned TAG_SH   = LINE_STEP_LOG2 + LINE_W
) (
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_we,
  input  logic [TOTAL-1:0]   status_flat,
  input  logic [TOTAL-1:0]   enable_flat,
  output logic [TOTAL-1:0]   w1c_flat,
  output logic [TOTAL-1:0]   en_set_flat,
  output logic [TOTAL-1:0]   en_clr_flat,
  output logic [NUM_LINES-1:0] ack_vec,
  output logic [DATA_W-1:0]  reg_rdata
);
  localparam logic [ADDR_W-1:0] BANK_TAG = ADDR_W'(BANK_BASE >> TAG_SH);

  logic              bank_hit;
  logic [LINE_W-1:0] sel_line;
  reg_kind_e         kind;
  logic              ack_hit;

  always_comb begin
    bank_hit = ((reg_addr >> TAG_SH) == BANK_TAG);
    sel_line = reg_addr[LINE_STEP_LOG2 +: LINE_W];
    kind     = KIND_NONE;
    if (bank_hit) begin
      case (reg_addr[3:0])
        NIB_STATUS: kind = KIND_STATUS;
        NIB_EN_SET: kind = KIND_EN_SET;
        NIB_EN_CLR: kind = KIND_EN_CLR;
        default:    kind = KIND_NONE;
      endcase
    end
    ack_hit = reg_we && (reg_addr == ADDR_W'(ACK_ADDR));
  end

  // Write strobes per line
  always_comb begin
    w1c_flat    = '0;
    en_set_flat = '0;
    en_clr_flat = '0;
    for (int ln = 0; ln < int'(NUM_LINES); ln++) begin
      if (reg_we && (sel_line == LINE_W'(ln))) begin
        if (kind == KIND_STATUS) w1c_flat[ln*VEC_BITS +: VEC_BITS]    = reg_wdata[VEC_BITS-1:0];
        if (kind == KIND_EN_SET) en_set_flat[ln*VEC_BITS +: VEC_BITS] = reg_wdata[VEC_BITS-1:0];
        if (kind == KIND_EN_CLR) en_clr_flat[ln*VEC_BITS +: VEC_BITS] = reg_wdata[VEC_BITS-1:0];
      end
    end
  end

  // Acknowledge decode: value ACK_BIAS + r selects line r
  generate
    for (genvar r = 0; r < NUM_LINES; r++) begin : g_ack
      assign ack_vec[r] = ack_hit && (reg_wdata == DATA_W'(ACK_BIAS + r));
    end
  endgenerate

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (kind)
      KIND_STATUS: reg_rdata = DATA_W'(status_flat[sel_line*VEC_BITS +: VEC_BITS]);
      KIND_EN_SET,
      KIND_EN_CLR: reg_rdata = DATA_W'(enable_flat[sel_line*VEC_BITS +: VEC_BITS]);
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_line.sv
module msi_line #(
  parameter int unsigned VEC_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VEC_BITS-1:0] set_i,
  input  logic [VEC_BITS-1:0] w1c_i,
  input  logic [VEC_BITS-1:0] en_set_i,
  input  logic [VEC_BITS-1:0] en_clr_i,
  input  logic                ack_i,
  output logic [VEC_BITS-1:0] status_o,
  output logic [VEC_BITS-1:0] enable_o,
  output logic                irq_o
);
  logic [VEC_BITS-1:0] status_q, status_d;
  logic [VEC_BITS-1:0] enable_q, enable_d;
  logic                blank_q, blank_d;
  logic                status_ce, enable_ce;

  // Next state: capture beats clear on the same bit
  always_comb begin
    status_ce = (|set_i) || (|w1c_i);
    status_d  = (status_q & ~w1c_i) | set_i;
    enable_ce = (|en_set_i) || (|en_clr_i);
    enable_d  = (enable_q | en_set_i) & ~en_clr_i;
    blank_d   = ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      blank_q  <= 1'b0;
    end else begin
      if (status_ce) status_q <= status_d;
      if (enable_ce) enable_q <= enable_d;
      blank_q <= blank_d;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = (|(status_q & enable_q)) && !blank_q;

  generate
    for (genvar b = 0; b < VEC_BITS; b++) begin : g_chk
      a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[b] |=> status_q[b]);
      a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_i[b] && !set_i[b]) |=> !status_q[b]);
      a_r5_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_i[b] && !en_clr_i[b]) |=> enable_q[b]);
      a_r5_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_i[b] |=> !enable_q[b]);
    end
  endgenerate

  a_r7_ack_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !irq_o);
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_i) && !(|w1c_i)) |=> $stable(status_q));
endmodule

// File: rtl/msi_agg.sv
module msi_agg #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned VEC_BITS  = 4,
  parameter int unsigned VEC_IN_W  = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic                 reg_we,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 msi_valid,
  input  logic [VEC_IN_W-1:0]  msi_vector,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int unsigned TOTAL = NUM_LINES * VEC_BITS;

  logic             rst_n_sync;
  logic [TOTAL-1:0] set_flat, w1c_flat, en_set_flat, en_clr_flat;
  logic [TOTAL-1:0] status_flat, enable_flat;
  logic [NUM_LINES-1:0] ack_vec;

  msi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  msi_capture_decode #(
    .NUM_LINES (NUM_LINES),
    .VEC_BITS  (VEC_BITS),
    .VEC_IN_W  (VEC_IN_W)
  ) u_cap (
    .msi_valid  (msi_valid),
    .msi_vector (msi_vector),
    .set_flat   (set_flat)
  );

  msi_regif #(
    .NUM_LINES (NUM_LINES),
    .VEC_BITS  (VEC_BITS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_regif (
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_we      (reg_we),
    .status_flat (status_flat),
    .enable_flat (enable_flat),
    .w1c_flat    (w1c_flat),
    .en_set_flat (en_set_flat),
    .en_clr_flat (en_clr_flat),
    .ack_vec     (ack_vec),
    .reg_rdata   (reg_rdata)
  );

  generate
    for (genvar r = 0; r < NUM_LINES; r++) begin : g_line
      msi_line #(.VEC_BITS(VEC_BITS)) u_line (
        .clk      (clk),
        .rst_n    (rst_n_sync),
        .set_i    (set_flat[r*VEC_BITS +: VEC_BITS]),
        .w1c_i    (w1c_flat[r*VEC_BITS +: VEC_BITS]),
        .en_set_i (en_set_flat[r*VEC_BITS +: VEC_BITS]),
        .en_clr_i (en_clr_flat[r*VEC_BITS +: VEC_BITS]),
        .ack_i    (ack_vec[r]),
        .status_o (status_flat[r*VEC_BITS +: VEC_BITS]),
        .enable_o (enable_flat[r*VEC_BITS +: VEC_BITS]),
        .irq_o    (irq_o[r])
      );
    end
  endgenerate

  a_r3_range_ignored: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (msi_valid && (msi_vector >= VEC_IN_W'(TOTAL)) && !reg_we) |=> $stable(status_flat));
  a_r1_single_capture: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $countones(set_flat) <= 1);
endmodule

// File: tb/msi_agg_tb.sv
module msi_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic [31:0] reg_rdata;
  logic        msi_valid;
  logic [7:0]  msi_vector;
  logic [7:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  msi_agg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
    .msi_vector(msi_vector), .irq_o(irq_o)
  );

  function automatic logic [11:0] st_addr(int r); return 12'(32'h104 + 16*r); endfunction
  function automatic logic [11:0] es_addr(int r); return 12'(32'h108 + 16*r); endfunction
  function automatic logic [11:0] ec_addr(int r); return 12'(32'h10C + 16*r); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic capture(logic [7:0] v);
    @(negedge clk);
    msi_valid = 1'b1; msi_vector = v;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic clear_all();
    for (int r = 0; r < 8; r++) begin
      reg_wr(st_addr(r), 32'hF);
      reg_wr(ec_addr(r), 32'hF);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int r = 0; r < 8; r++) begin
      reg_rd(st_addr(r), d); chk("R1 status after reset", d, 0);
      reg_rd(es_addr(r), d); chk("R1 enable after reset", d, 0);
    end
    chk("R1 irq after reset", 32'(irq_o), 0);
  endtask

  task automatic t_mapping();
    logic [31:0] d;
    int vecs[5] = '{0, 8, 17, 25, 31};
    foreach (vecs[i]) begin
      clear_all();
      capture(8'(vecs[i]));
      reg_rd(st_addr(vecs[i] % 8), d);
      chk("R2 vector lands at line v mod 8, bit v>>3", d, 32'(1 << (vecs[i] >> 3)));
      reg_rd(st_addr((vecs[i] + 1) % 8), d);
      chk("R2 neighbouring line untouched", d, 0);
    end
  endtask

  task automatic t_range();
    logic [31:0] d;
    clear_all();
    for (int r = 0; r < 8; r++) reg_wr(es_addr(r), 32'hF);
    capture(8'd32); capture(8'd40); capture(8'd255);
    for (int r = 0; r < 8; r++) begin
      reg_rd(st_addr(r), d); chk("R3 out-of-range vector ignored", d, 0);
    end
    chk("R3 no irq from out-of-range", 32'(irq_o), 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    clear_all();
    capture(8'd3); capture(8'd11); capture(8'd27);  // line 3 bits 0,1,3
    reg_rd(st_addr(3), d); chk("R2 three bits pending", d, 32'hB);
    reg_wr(st_addr(3), 32'h2);
    reg_rd(st_addr(3), d); chk("R4 only written bit cleared", d, 32'h9);
    reg_wr(st_addr(3), 32'h0);
    reg_rd(st_addr(3), d); chk("R4 zero write keeps bits", d, 32'h9);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    clear_all();
    reg_wr(es_addr(6), 32'h5);
    reg_rd(es_addr(6), d); chk("R5 set read via set offset", d, 32'h5);
    reg_wr(es_addr(6), 32'h2);
    reg_rd(ec_addr(6), d); chk("R5 set accumulates, read via clear offset", d, 32'h7);
    reg_wr(ec_addr(6), 32'h4);
    reg_rd(es_addr(6), d); chk("R5 clear removes only written bit", d, 32'h3);
    reg_rd(es_addr(5), d); chk("R5 other line enable untouched", d, 0);
  endtask

  task automatic t_irq();
    clear_all();
    reg_wr(es_addr(1), 32'h4);          // enable vector 17
    capture(8'd9);                       // line 1 bit 1, not enabled
    chk("R6 disabled bit gives no irq", 32'(irq_o), 0);
    capture(8'd17);                      // line 1 bit 2, enabled
    chk("R6 enabled pending bit raises line 1", 32'(irq_o), 32'h02);
    reg_wr(st_addr(1), 32'h4);
    chk("R6 irq drops when enabled bit cleared", 32'(irq_o), 0);
  endtask

  task automatic t_pending_disabled();
    logic [31:0] d;
    clear_all();
    capture(8'd5);
    chk("R9 disabled vector keeps irq low", 32'(irq_o), 0);
    reg_rd(st_addr(5), d); chk("R9 disabled vector still pending", d, 32'h1);
    reg_wr(es_addr(5), 32'h1);
    chk("R9 enabling raises irq", 32'(irq_o), 32'h20);
  endtask

  task automatic t_ack();
    clear_all();
    reg_wr(es_addr(2), 32'h2);
    reg_wr(es_addr(3), 32'h1);
    capture(8'd10);  // line 2 bit 1
    capture(8'd3);   // line 3 bit 0
    chk("R7 both lines up before ack", 32'(irq_o), 32'h0C);
    reg_wr(12'h050, 32'd6);
    chk("R7 acked line low for one cycle, other line holds", 32'(irq_o), 32'h08);
    @(negedge clk);
    chk("R7 acked line reasserts while pending", 32'(irq_o), 32'h0C);
    reg_wr(12'h050, 32'd3);
    chk("R7 value below range acknowledges nothing", 32'(irq_o), 32'h0C);
    reg_wr(12'h050, 32'd12);
    chk("R7 value above range acknowledges nothing", 32'(irq_o), 32'h0C);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    clear_all();
    capture(8'd20);  // line 4 bit 2
    @(negedge clk);
    msi_valid = 1'b1; msi_vector = 8'd20;
    reg_addr = st_addr(4); reg_wdata = 32'h4; reg_we = 1'b1;
    @(negedge clk);
    msi_valid = 1'b0; reg_we = 1'b0;
    reg_rd(st_addr(4), d); chk("R8 capture wins over same-cycle clear", d, 32'h4);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
    msi_valid = 1'b0; msi_vector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mapping();
    t_range();
    t_w1c();
    t_enable();
    t_irq();
    t_pending_disabled();
    t_ack();
    t_collision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule